// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the coherence controller for one small write-back cache on a shared snooping bus. The cache is direct-mapped and holds one data word per line. When a line is shared, a store is not turned into an invalidation. The controller stalls the store, puts the new word on the bus, and every other cache holding the line takes that word in place. A line that is present is always in one of four states: exclusive-clean, shared-clean, shared-owned or dirty. Absence is shown only by a clear present bit, so misses are handled as their own events and there is no invalid state.

The processor side is a valid/ready request stream and a valid/ready response stream. The controller accepts one request when `cpu_req_ready` is high, and it holds `cpu_req_ready` low until the matching response has been taken. The response, including its data, stays stable while `cpu_rsp_ready` is low. Writes are acknowledged with the word that was stored.

The bus master side has one request channel. `bus_req_valid` is held with a stable command and address until the bus grants it with `bus_req_ready`. In the grant cycle the bus drives `bus_rsp_data` and the wired-OR shared line `bus_shared_in`. The snoop side receives transactions from other caches on `snp_*`. In the same cycle it answers combinationally on `snp_shared`, `snp_supply` and `snp_rdata`, and it updates its line state at the clock edge. The bus never grants this cache in a cycle that carries a snoop.

Top module: `upd_coh_cache`

## Requirements
- R1: After reset no line is present. Every first access misses and issues a bus read, snoops get no shared or supply response, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `bus_req_valid` are 0.
- R2: A read miss issues a read (command code 1) and returns `bus_rsp_data`. The line is installed shared-clean if `bus_shared_in` is high at the grant, and exclusive-clean otherwise.
- R3: A read hit returns the stored word without a bus request. A write hit on a dirty line stores the word without a bus request.
- R4: A write hit on an exclusive-clean line stores the word without a bus request, and the line becomes dirty.
- R5: A write hit on a shared-clean or shared-owned line issues an update (code 2) that carries the line address and the new word. The line then becomes shared-owned if `bus_shared_in` is high at the grant, and dirty otherwise.
- R6: A write miss first issues a read. If the shared line was high, an update with the new word follows and the line ends shared-owned. If it was low, no update is issued and the line ends dirty.
- R7: A snooped read (code 1) that hits raises `snp_shared`. A dirty or shared-owned line also raises `snp_supply` with its word on `snp_rdata`, and a dirty line becomes shared-owned. An exclusive-clean line becomes shared-clean.
- R8: A snooped update (code 2) that hits raises `snp_shared`, replaces the stored word with `snp_data`, and sets the line to shared-clean.
- R9: A snoop that misses, or that carries a write-back (code 3), raises nothing and changes no line.
- R10: A miss that evicts a dirty or shared-owned line first issues a write-back (code 3) with the victim's address and word, then issues the read. Evicting an exclusive-clean or shared-clean line issues no write-back.
- R11: Only one processor request is outstanding at a time. While `cpu_rsp_valid` is high and `cpu_rsp_ready` is low, the response and its data hold and `cpu_req_ready` stays low.
- R12: While `bus_req_valid` is high and not granted, the command and address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller accepts a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address (low bits index the line) |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DATA_W | Loaded word, or the stored word for a store |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_ready | input | 1 | Bus grant; the transaction happens in this cycle |
| bus_req_cmd | output | 2 | 1 read, 2 update, 3 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Update word or write-back word |
| bus_rsp_data | input | DATA_W | Fill word in a read grant |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled at a grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache's share of the wired-OR shared line |
| snp_supply | output | 1 | This cache supplies the snooped read's data |
| snp_rdata | output | DATA_W | Supplied word |

## Verification
Line state cannot be seen directly. A wrong state shows at the ports within a single operation: it changes whether the next store to that line produces an update, whether a snooped read is supplied, and whether an eviction writes back. The bench keeps a reference copy of every line's state and word. It predicts the exact bus command sequence, the addresses, the data and the snoop answers for every operation, so a wrong transition is caught at the next touch of that line. A wrong word is caught by the next load or supplied snoop.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

  typedef enum logic [1:0] {
    LS_EXCL  = 2'd0,
    LS_SHCLN = 2'd1,
    LS_SHMOD = 2'd2,
    LS_DIRTY = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'd0,
    BC_READ   = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOOK,
    PH_WBACK,
    PH_FILL,
    PH_UPD,
    PH_RESP
  } phase_e;

  // Lines this cache must write back or supply: it owns the freshest copy.
  function automatic logic is_owner(line_st_e s);
    return (s == LS_SHMOD) || (s == LS_DIRTY);
  endfunction

endpackage

// File: rtl/upd_line_array.sv
module upd_line_array
  import upd_coh_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // read port A: processor side
  input  logic [IDX_W-1:0]  pa_idx,
  output logic              pa_pres,
  output line_st_e          pa_st,
  output logic [TAG_W-1:0]  pa_tag,
  output logic [DATA_W-1:0] pa_data,
  // read port B: snoop side
  input  logic [IDX_W-1:0]  pb_idx,
  output logic              pb_pres,
  output line_st_e          pb_st,
  output logic [TAG_W-1:0]  pb_tag,
  output logic [DATA_W-1:0] pb_data,
  // local write (full line)
  input  logic              lw_en,
  input  logic [IDX_W-1:0]  lw_idx,
  input  logic              lw_pres,
  input  line_st_e          lw_st,
  input  logic [TAG_W-1:0]  lw_tag,
  input  logic [DATA_W-1:0] lw_data,
  // snoop write (state and word)
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_e          sw_st,
  input  logic [DATA_W-1:0] sw_data
);

  logic              pres_v [LINES];
  line_st_e          st_v   [LINES];
  logic [TAG_W-1:0]  tag_v  [LINES];
  logic [DATA_W-1:0] data_v [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              p_q;
    line_st_e          s_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_q <= 1'b0;
        s_q <= LS_EXCL;
        t_q <= '0;
        d_q <= '0;
      end else if (lw_en && lw_idx == IDX_W'(g)) begin
        p_q <= lw_pres;
        s_q <= lw_st;
        t_q <= lw_tag;
        d_q <= lw_data;
      end else if (sw_en && sw_idx == IDX_W'(g)) begin
        s_q <= sw_st;
        d_q <= sw_data;
      end
    end

    assign pres_v[g] = p_q;
    assign st_v[g]   = s_q;
    assign tag_v[g]  = t_q;
    assign data_v[g] = d_q;
  end

  assign pa_pres = pres_v[pa_idx];
  assign pa_st   = st_v[pa_idx];
  assign pa_tag  = tag_v[pa_idx];
  assign pa_data = data_v[pa_idx];

  assign pb_pres = pres_v[pb_idx];
  assign pb_st   = st_v[pb_idx];
  assign pb_tag  = tag_v[pb_idx];
  assign pb_data = data_v[pb_idx];

endmodule

// File: rtl/upd_snoop_resp.sv
module upd_snoop_resp
  import upd_coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic [IDX_W-1:0]  ln_idx,
  input  logic              ln_pres,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_rdata,
  output logic              sw_en,
  output line_st_e          sw_st,
  output logic [DATA_W-1:0] sw_data
);

  bus_cmd_e cmd;
  logic     hit, rd_hit, up_hit;

  always_comb begin
    ln_idx = snp_addr[IDX_W-1:0];
    cmd    = bus_cmd_e'(snp_cmd);
    hit    = snp_valid && ln_pres && (ln_tag == snp_addr[ADDR_W-1:IDX_W]);
    rd_hit = hit && (cmd == BC_READ);
    up_hit = hit && (cmd == BC_UPDATE);

    snp_shared = rd_hit || up_hit;
    snp_supply = rd_hit && is_owner(ln_st);
    snp_rdata  = snp_supply ? ln_data : '0;

    sw_en   = rd_hit || up_hit;
    sw_st   = ln_st;
    sw_data = ln_data;
    if (up_hit) begin
      sw_st   = LS_SHCLN;
      sw_data = snp_data;
    end else if (rd_hit) begin
      unique case (ln_st)
        LS_EXCL:  sw_st = LS_SHCLN;
        LS_DIRTY: sw_st = LS_SHMOD;
        default:  sw_st = ln_st;
      endcase
    end
  end

endmodule

// File: rtl/upd_proc_fsm.sv
module upd_proc_fsm
  import upd_coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic [DATA_W-1:0] bus_rsp_data,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  output logic [IDX_W-1:0]  pa_idx,
  input  logic              pa_pres,
  input  line_st_e          pa_st,
  input  logic [TAG_W-1:0]  pa_tag,
  input  logic [DATA_W-1:0] pa_data,
  output logic              lw_en,
  output logic              lw_pres,
  output line_st_e          lw_st,
  output logic [TAG_W-1:0]  lw_tag,
  output logic [DATA_W-1:0] lw_data
);

  phase_e            phase_q, phase_d;
  logic              rq_wr_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wdata_q;
  logic [DATA_W-1:0] rsp_q, rsp_d;

  logic [IDX_W-1:0]  rq_idx;
  logic [TAG_W-1:0]  rq_tag;
  logic              hit, fire;

  assign rq_idx = rq_addr_q[IDX_W-1:0];
  assign rq_tag = rq_addr_q[ADDR_W-1:IDX_W];
  assign pa_idx = rq_idx;
  assign hit    = pa_pres && (pa_tag == rq_tag);
  assign fire   = bus_req_valid && bus_req_ready;

  always_comb begin
    phase_d = phase_q;
    rsp_d   = rsp_q;
    lw_en   = 1'b0;
    lw_pres = pa_pres;
    lw_st   = pa_st;
    lw_tag  = pa_tag;
    lw_data = pa_data;
    unique case (phase_q)
      PH_IDLE: if (cpu_req_valid) phase_d = PH_LOOK;
      PH_LOOK: begin
        // A snoop in this cycle may change the line; decide one cycle later.
        if (!snp_valid) begin
          if (hit) begin
            if (!rq_wr_q) begin
              rsp_d   = pa_data;
              phase_d = PH_RESP;
            end else if (pa_st == LS_EXCL || pa_st == LS_DIRTY) begin
              lw_en   = 1'b1;
              lw_st   = LS_DIRTY;
              lw_data = rq_wdata_q;
              rsp_d   = rq_wdata_q;
              phase_d = PH_RESP;
            end else begin
              phase_d = PH_UPD;
            end
          end else if (pa_pres && is_owner(pa_st)) begin
            phase_d = PH_WBACK;
          end else begin
            phase_d = PH_FILL;
          end
        end
      end
      PH_WBACK: if (fire) begin
        lw_en   = 1'b1;
        lw_pres = 1'b0;
        phase_d = PH_FILL;
      end
      PH_FILL: if (fire) begin
        lw_en   = 1'b1;
        lw_pres = 1'b1;
        lw_tag  = rq_tag;
        lw_data = bus_rsp_data;
        if (!rq_wr_q) begin
          lw_st   = bus_shared_in ? LS_SHCLN : LS_EXCL;
          rsp_d   = bus_rsp_data;
          phase_d = PH_RESP;
        end else if (bus_shared_in) begin
          lw_st   = LS_SHCLN;
          phase_d = PH_UPD;
        end else begin
          lw_st   = LS_DIRTY;
          lw_data = rq_wdata_q;
          rsp_d   = rq_wdata_q;
          phase_d = PH_RESP;
        end
      end
      PH_UPD: if (fire) begin
        lw_en   = 1'b1;
        lw_st   = bus_shared_in ? LS_SHMOD : LS_DIRTY;
        lw_data = rq_wdata_q;
        rsp_d   = rq_wdata_q;
        phase_d = PH_RESP;
      end
      PH_RESP: if (cpu_rsp_ready) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      rq_wr_q    <= 1'b0;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
      rsp_q      <= '0;
    end else begin
      phase_q <= phase_d;
      rsp_q   <= rsp_d;
      if (phase_q == PH_IDLE && cpu_req_valid) begin
        rq_wr_q    <= cpu_req_write;
        rq_addr_q  <= cpu_req_addr;
        rq_wdata_q <= cpu_req_wdata;
      end
    end
  end

  always_comb begin
    cpu_req_ready = (phase_q == PH_IDLE);
    cpu_rsp_valid = (phase_q == PH_RESP);
    cpu_rsp_rdata = rsp_q;
    bus_req_valid = 1'b0;
    bus_req_cmd   = BC_IDLE;
    bus_req_addr  = rq_addr_q;
    bus_req_data  = '0;
    unique case (phase_q)
      PH_WBACK: begin
        bus_req_valid = 1'b1;
        bus_req_cmd   = BC_WBACK;
        bus_req_addr  = {pa_tag, rq_idx};
        bus_req_data  = pa_data;
      end
      PH_FILL: begin
        bus_req_valid = 1'b1;
        bus_req_cmd   = BC_READ;
      end
      PH_UPD: begin
        bus_req_valid = 1'b1;
        bus_req_cmd   = BC_UPDATE;
        bus_req_data  = rq_wdata_q;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/upd_coh_cache.sv
module upd_coh_cache
  import upd_coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic [DATA_W-1:0] bus_rsp_data,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_rdata
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  pa_idx, pb_idx, lw_idx_unused;
  logic              pa_pres, pb_pres;
  line_st_e          pa_st, pb_st;
  logic [TAG_W-1:0]  pa_tag, pb_tag;
  logic [DATA_W-1:0] pa_data, pb_data;
  logic              lw_en, lw_pres;
  line_st_e          lw_st;
  logic [TAG_W-1:0]  lw_tag;
  logic [DATA_W-1:0] lw_data;
  logic              sw_en;
  line_st_e          sw_st;
  logic [DATA_W-1:0] sw_data;

  assign lw_idx_unused = pa_idx;

  upd_proc_fsm #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_req_data(bus_req_data),
    .bus_rsp_data(bus_rsp_data), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid),
    .pa_idx(pa_idx), .pa_pres(pa_pres), .pa_st(pa_st),
    .pa_tag(pa_tag), .pa_data(pa_data),
    .lw_en(lw_en), .lw_pres(lw_pres), .lw_st(lw_st),
    .lw_tag(lw_tag), .lw_data(lw_data)
  );

  upd_line_array #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_n),
    .pa_idx(pa_idx), .pa_pres(pa_pres), .pa_st(pa_st),
    .pa_tag(pa_tag), .pa_data(pa_data),
    .pb_idx(pb_idx), .pb_pres(pb_pres), .pb_st(pb_st),
    .pb_tag(pb_tag), .pb_data(pb_data),
    .lw_en(lw_en), .lw_idx(lw_idx_unused), .lw_pres(lw_pres),
    .lw_st(lw_st), .lw_tag(lw_tag), .lw_data(lw_data),
    .sw_en(sw_en), .sw_idx(pb_idx), .sw_st(sw_st), .sw_data(sw_data)
  );

  upd_snoop_resp #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_data(snp_data),
    .ln_idx(pb_idx), .ln_pres(pb_pres), .ln_st(pb_st),
    .ln_tag(pb_tag), .ln_data(pb_data),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_rdata(snp_rdata),
    .sw_en(sw_en), .sw_st(sw_st), .sw_data(sw_data)
  );

endmodule

// File: rtl/upd_coh_cache_chk.sv
module upd_coh_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic [DATA_W-1:0] cpu_rsp_rdata,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [1:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_shared,
  input logic              snp_supply
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cpu_rsp_valid && !bus_req_valid && cpu_req_ready)); // R1

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req_ready && cpu_rsp_valid)); // R11

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata))); // R11

  AST_BUS_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr))); // R12

  AST_SUPPLY_IS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared); // R7

  AST_WBACK_SNOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd3) |-> (!snp_shared && !snp_supply)); // R9

  AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !bus_req_valid); // R3

endmodule

bind upd_coh_cache upd_coh_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_shared(snp_shared), .snp_supply(snp_supply)
);

// File: tb/upd_coh_cache_tb.sv
module upd_coh_cache_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0, cpu_rsp_ready = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [15:0] cpu_rsp_rdata;
  logic        bus_req_valid, bus_req_ready = 1'b0, bus_shared_in = 1'b0;
  logic [1:0]  bus_req_cmd;
  logic [7:0]  bus_req_addr;
  logic [15:0] bus_req_data, bus_rsp_data = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [7:0]  snp_addr = '0;
  logic [15:0] snp_data = '0;
  logic        snp_shared, snp_supply;
  logic [15:0] snp_rdata;

  always #5 clk = ~clk;

  upd_coh_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_req_data(bus_req_data),
    .bus_rsp_data(bus_rsp_data), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_data(snp_data),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_rdata(snp_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // Reference line model: state 0 excl-clean, 1 shared-clean, 2 shared-owned, 3 dirty
  bit          m_pres [8];
  int          m_st   [8];
  logic [4:0]  m_tag  [8];
  logic [15:0] m_data [8];

  int          e_n;
  logic [1:0]  e_cmd  [4];
  logic [7:0]  e_addr [4];
  logic [15:0] e_data [4];
  logic [15:0] e_rdata;
  string       e_req;

  function automatic void push(logic [1:0] c, logic [7:0] a, logic [15:0] d);
    e_cmd[e_n] = c; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
  endfunction

  function automatic void model_op(bit wr, logic [7:0] a, logic [15:0] w, bit sh, logic [15:0] mem);
    logic [2:0] ix = a[2:0];
    logic [4:0] tg = a[7:3];
    e_n = 0;
    if (m_pres[ix] && m_tag[ix] == tg) begin
      if (!wr) begin
        e_rdata = m_data[ix]; e_req = "R3";
      end else if (m_st[ix] == 3) begin
        m_data[ix] = w; e_rdata = w; e_req = "R3";
      end else if (m_st[ix] == 0) begin
        m_data[ix] = w; m_st[ix] = 3; e_rdata = w; e_req = "R4";
      end else begin
        push(2'd2, a, w); m_st[ix] = sh ? 2 : 3; m_data[ix] = w; e_rdata = w; e_req = "R5";
      end
    end else begin
      e_req = m_pres[ix] ? "R10" : (wr ? "R6" : "R2");
      if (m_pres[ix] && m_st[ix] >= 2) push(2'd3, {m_tag[ix], ix}, m_data[ix]);
      push(2'd1, a, 16'h0);
      m_pres[ix] = 1'b1; m_tag[ix] = tg;
      if (!wr) begin
        m_st[ix] = sh ? 1 : 0; m_data[ix] = mem; e_rdata = mem;
      end else if (sh) begin
        push(2'd2, a, w); m_st[ix] = 2; m_data[ix] = w; e_rdata = w;
      end else begin
        m_st[ix] = 3; m_data[ix] = w; e_rdata = w;
      end
    end
  endfunction

  function automatic void model_snp(logic [1:0] c, logic [7:0] a, logic [15:0] d,
                                    output bit sh, output bit sup,
                                    output logic [15:0] rd, output string rq);
    logic [2:0] ix = a[2:0];
    bit hit = m_pres[ix] && m_tag[ix] == a[7:3];
    sh = 1'b0; sup = 1'b0; rd = '0; rq = "R9";
    if (hit && c == 2'd1) begin
      sh = 1'b1; sup = (m_st[ix] >= 2); rd = sup ? m_data[ix] : 16'h0; rq = "R7";
      if (m_st[ix] == 0) m_st[ix] = 1;
      else if (m_st[ix] == 3) m_st[ix] = 2;
    end else if (hit && c == 2'd2) begin
      sh = 1'b1; m_data[ix] = d; m_st[ix] = 1; rq = "R8";
    end
  endfunction

  task automatic run_op(bit wr, logic [7:0] a, logic [15:0] w, bit sh, logic [15:0] mem,
                        int rsp_dly, int bus_dly);
    int          n = 0;
    logic [1:0]  gc [4];
    logic [7:0]  ga [4];
    logic [15:0] gd [4];
    logic [15:0] rd = '0;
    bit          done = 1'b0;
    int          guard = 0;
    model_op(wr, a, w, sh, mem);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = w;
    @(posedge clk); #1 cpu_req_valid = 1'b0;
    @(negedge clk);
    while (!done && guard < 60) begin
      guard++;
      if (cpu_rsp_valid) begin
        rd = cpu_rsp_rdata;
        for (int k = 0; k < rsp_dly; k++) begin
          @(negedge clk);
          chk(cpu_rsp_valid && !cpu_req_ready && cpu_rsp_rdata == rd, "R11 rsp hold",
              {cpu_rsp_valid, cpu_req_ready}, 2'b10);
        end
        cpu_rsp_ready = 1'b1;
        @(posedge clk); #1 cpu_rsp_ready = 1'b0;
        done = 1'b1;
      end else if (bus_req_valid) begin
        logic [1:0] c0 = bus_req_cmd;
        logic [7:0] a0 = bus_req_addr;
        for (int k = 0; k < bus_dly; k++) begin
          @(negedge clk);
          chk(bus_req_valid && bus_req_cmd == c0 && bus_req_addr == a0, "R12 bus hold",
              {bus_req_valid, bus_req_cmd, bus_req_addr}, {1'b1, c0, a0});
        end
        if (n < 4) begin
          gc[n] = bus_req_cmd; ga[n] = bus_req_addr; gd[n] = bus_req_data;
        end
        n++;
        bus_req_ready = 1'b1; bus_rsp_data = mem; bus_shared_in = sh;
        @(posedge clk); #1 bus_req_ready = 1'b0;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
    chk(done, {e_req, " completion"}, done, 1);
    chk(n == e_n, {e_req, " bus transaction count"}, n, e_n);
    for (int i = 0; i < e_n && i < n && i < 4; i++) begin
      chk(gc[i] == e_cmd[i], {e_req, " bus cmd"}, gc[i], e_cmd[i]);
      chk(ga[i] == e_addr[i], {e_req, " bus addr"}, ga[i], e_addr[i]);
      if (e_cmd[i] != 2'd1)
        chk(gd[i] == e_data[i], {e_req, " bus data"}, gd[i], e_data[i]);
    end
    chk(rd == e_rdata, {e_req, " response data"}, rd, e_rdata);
  endtask

  task automatic run_snp(logic [1:0] c, logic [7:0] a, logic [15:0] d);
    bit sh, sup;
    logic [15:0] rd;
    string rq;
    model_snp(c, a, d, sh, sup, rd, rq);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_data = d;
    #1;
    chk(snp_shared == sh, {rq, " snoop shared"}, snp_shared, sh);
    chk(snp_supply == sup, {rq, " snoop supply"}, snp_supply, sup);
    if (sup) chk(snp_rdata == rd, {rq, " snoop data"}, snp_rdata, rd);
    @(posedge clk); #1 snp_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) begin
      m_pres[i] = 1'b0; m_st[i] = 0; m_tag[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle outputs during reset
    chk(cpu_req_ready && !cpu_rsp_valid && !bus_req_valid, "R1 reset outputs",
        {cpu_req_ready, cpu_rsp_valid, bus_req_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready && !cpu_rsp_valid && !bus_req_valid, "R1 after reset",
        {cpu_req_ready, cpu_rsp_valid, bus_req_valid}, 3'b100);
    run_snp(2'd1, 8'h10, 16'h0);                       // R1: nothing present
    run_op(1'b0, 8'h10, 16'h0, 1'b0, 16'hA001, 0, 0);  // R1/R2 miss -> excl-clean
    run_op(1'b0, 8'h10, 16'h0, 1'b1, 16'h0, 0, 0);     // R3 read hit
    run_op(1'b1, 8'h10, 16'hB001, 1'b1, 16'h0, 0, 0);  // R4 excl write, silent
    run_op(1'b1, 8'h10, 16'hB002, 1'b1, 16'h0, 0, 0);  // R3 dirty write, silent
    run_snp(2'd1, 8'h10, 16'h0);                       // R7 dirty supplies -> owned
    run_op(1'b1, 8'h10, 16'hB003, 1'b1, 16'h0, 0, 2);  // R5 owned update, shared; R12
    run_snp(2'd2, 8'h10, 16'hC001);                    // R8 update taken -> shared-clean
    run_op(1'b0, 8'h10, 16'h0, 1'b0, 16'h0, 3, 0);     // R8 word visible; R11 hold
    run_snp(2'd1, 8'h10, 16'h0);                       // R7 shared-clean: no supply
    run_op(1'b1, 8'h10, 16'hB004, 1'b0, 16'h0, 0, 0);  // R5 update alone -> dirty
    run_op(1'b0, 8'h18, 16'h0, 1'b1, 16'hA002, 0, 1);  // R10 write-back then read
    run_op(1'b0, 8'h20, 16'h0, 1'b0, 16'hA003, 0, 0);  // R10 shared-clean evict silent
    run_op(1'b0, 8'h28, 16'h0, 1'b0, 16'hA004, 0, 0);  // R10 excl-clean evict silent
    run_op(1'b1, 8'h33, 16'hD001, 1'b1, 16'hA005, 0, 0); // R6 read + update -> owned
    run_snp(2'd1, 8'h33, 16'h0);                       // R6/R7 owned supplies
    run_op(1'b1, 8'h44, 16'hD002, 1'b0, 16'hA006, 0, 0); // R6 read only -> dirty
    run_snp(2'd1, 8'h44, 16'h0);                       // R6/R7 dirty supplies
    run_snp(2'd1, 8'h99, 16'h0);                       // R9 miss on absent line
    run_snp(2'd3, 8'h44, 16'hEEEE);                    // R9 write-back snoop ignored
    run_op(1'b0, 8'h44, 16'h0, 1'b0, 16'h0, 0, 0);     // R9 word unchanged
    run_snp(2'd2, 8'h0C, 16'h1234);                    // R9 tag mismatch on idx 4
    run_op(1'b0, 8'h44, 16'h0, 1'b0, 16'h0, 0, 0);     // R9 still unchanged
    for (int it = 0; it < 400; it++) begin
      logic [7:0] a = {5'($urandom % 3), 3'($urandom % 8)};
      if ($urandom % 10 < 3)
        run_snp(2'(1 + $urandom % 3), a, 16'($urandom));
      else
        run_op(1'($urandom % 2), a, 16'($urandom), 1'($urandom % 2), 16'($urandom),
               int'($urandom % 3), int'($urandom % 3));
    end
    summary();
    $finish;
  end

endmodule